// File: doc/BRIEF.md
# Scan-Strobed Retentive Up/Down Counter

The block keeps one counting element as three words: a packed status word, a preset word and a signed two's-complement accumulator. Two condition inputs, one for counting up and one for counting down, are sampled only when a scan strobe is high. A condition that was false at the previous strobe and is true at this one moves the accumulator by one. A condition that stays true moves it once only.

The status word holds the sampled condition levels, a done flag, and sticky overflow and underflow flags, each at a fixed bit position. Logic elsewhere can decode those positions. A synchronous clear returns the accumulator and the status to zero and keeps the preset. A load port overwrites the accumulator with any value, so a count-down job can start from a batch size and run toward a preset of zero. A single-cycle pulse marks the first wrap in each direction.

The state lives in plain registers. Only the asynchronous reset and the clear change it, which is how the block models a count that must survive between uses.

Top module: `scan_counter_elem`

## Requirements
- R1: While `rst_n` is low, and in the cycle after a clock edge that sees `clr` high, `accum_word` and `status_word` read 0 and both pulses are low. `clr` leaves `preset_word` unchanged.
- R2: When `scan` is high, `cu_cond` is high and `cu_cond` was low at the previous strobe, `accum_word` rises by one after that edge. A condition held high over several strobes adds one only. Changes while `scan` is low are not seen.
- R3: When `scan` is high, `cd_cond` is high and `cd_cond` was low at the previous strobe, `accum_word` falls by one after that edge.
- R4: Status bit 15 shows `cu_cond` and bit 14 shows `cd_cond` as sampled at the most recent strobe.
- R5: Status bit 13 (done) is 1 exactly when the signed accumulator is greater than or equal to the signed preset. R8 gives the one exception.
- R6: Counting up from 0x7FFF gives 0x8000 and sets status bit 12 (overflow). The bit then stays set until clear or reset. `ovf_pulse` is high for one cycle, in the cycle the bit first becomes 1.
- R7: Counting down from 0x8000 gives 0x7FFF and sets status bit 11 (underflow). The bit then stays set until clear or reset. `unf_pulse` is high for one cycle, in the cycle the bit first becomes 1.
- R8: While the overflow bit is set, a done bit that is 1 stays 1, even when the wrapped accumulator is below the preset.
- R9: `load_en` writes `load_val` into the accumulator at the next edge. Priority is clear, then load, then counting. A count edge in the same cycle as a load is dropped.
- R10: An up edge and a down edge at the same strobe leave the accumulator unchanged.
- R11: The first strobe after reset or clear only samples the conditions. A condition already high at that strobe does not count.
- R12: `preset_we` writes `preset_val` into `preset_word` at the next edge. Status bits 10 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low, clears all state including the preset |
| clr | input | 1 | Synchronous clear of accumulator and status |
| scan | input | 1 | Scan strobe; conditions are sampled only when it is high |
| cu_cond | input | 1 | Count-up condition level |
| cd_cond | input | 1 | Count-down condition level |
| load_en | input | 1 | Accumulator write enable |
| load_val | input | 16 | Value written by `load_en` |
| preset_we | input | 1 | Preset write enable |
| preset_val | input | 16 | Value written by `preset_we` |
| status_word | output | 16 | Packed status: 15 up level, 14 down level, 13 done, 12 overflow, 11 underflow |
| preset_word | output | 16 | Current preset |
| accum_word | output | 16 | Signed accumulator |
| ovf_pulse | output | 1 | One-cycle pulse when overflow first sets |
| unf_pulse | output | 1 | One-cycle pulse when underflow first sets |

## Verification
Directed sequences check these cases:
- A single rising condition, which must count once.
- A held condition, which must not count again.
- Toggling without a strobe, which must be ignored.
- Simultaneous up and down edges, which must cancel.
- Loads to 0x7FFF and 0x8000, which expose the wrap, the sticky flags, the pulses and the held done bit.

A count down from 50 to a preset of 0 shows where done follows the signed compare. A condition high across a clear shows whether the first strobe is armed.

Random strobes, condition levels, loads biased toward the extremes, preset writes and rare clears are then compared every cycle with a bench model. These runs reach the priority orderings that the directed cases do not combine.

// File: rtl/scnt_pkg.sv
package scnt_pkg;

   // Kind of change applied to the accumulator in one cycle.
   typedef enum logic [2:0] {
      ACC_HOLD  = 3'd0,
      ACC_UP    = 3'd1,
      ACC_DOWN  = 3'd2,
      ACC_LOAD  = 3'd3,
      ACC_CLEAR = 3'd4
   } acc_step_e;

   // Status bit positions, measured down from the top bit of a W-bit word.
   localparam int unsigned OFS_CU = 1;
   localparam int unsigned OFS_CD = 2;
   localparam int unsigned OFS_DN = 3;
   localparam int unsigned OFS_OV = 4;
   localparam int unsigned OFS_UN = 5;
   localparam int unsigned OFS_UA = 6;

   localparam int unsigned MIN_WIDTH = 8;

endpackage

// File: rtl/scnt_edge.sv
// One condition channel: samples a level at each scan strobe and reports a
// false-to-true change. The first strobe after reset or clear only arms.
module scnt_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic scan,
   input  logic cond,
   output logic rise_o,
   output logic level_o
);

   logic prev_q;
   logic armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (clr) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else if (scan) begin
         prev_q  <= cond;
         armed_q <= 1'b1;
      end
   end

   assign rise_o  = scan & armed_q & cond & ~prev_q;
   assign level_o = prev_q;

endmodule

// File: rtl/scnt_accum.sv
// Signed accumulator with clear > load > count priority and
// two's-complement wrap detection.
module scnt_accum
   import scnt_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         up_rise,
   input  logic         dn_rise,
   output logic [W-1:0] acc_o,
   output logic [W-1:0] acc_next_o,
   output logic         wrap_up_o,
   output logic         wrap_dn_o
);

   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] ONE     = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] acc_q;
   logic [W-1:0] acc_d;
   acc_step_e    step;

   always_comb begin
      if (clr)                      step = ACC_CLEAR;
      else if (load_en)             step = ACC_LOAD;
      else if (up_rise && !dn_rise) step = ACC_UP;
      else if (dn_rise && !up_rise) step = ACC_DOWN;
      else                          step = ACC_HOLD;
   end

   always_comb begin
      acc_d     = acc_q;
      wrap_up_o = 1'b0;
      wrap_dn_o = 1'b0;
      unique case (step)
         ACC_CLEAR: acc_d = '0;
         ACC_LOAD:  acc_d = load_val;
         ACC_UP: begin
            acc_d     = acc_q + ONE;
            wrap_up_o = (acc_q == MAX_POS);
         end
         ACC_DOWN: begin
            acc_d     = acc_q - ONE;
            wrap_dn_o = (acc_q == MIN_NEG);
         end
         default:   acc_d = acc_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else        acc_q <= acc_d;
   end

   assign acc_o      = acc_q;
   assign acc_next_o = acc_d;

endmodule

// File: rtl/scnt_status.sv
// Done, overflow and underflow flags, the wrap pulses and the packing of
// the status word.
module scnt_status
   import scnt_pkg::*;
#(
   parameter int unsigned W              = 16,
   parameter bit          HOLD_DONE_WRAP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] acc_next,
   input  logic [W-1:0] preset_next,
   input  logic         wrap_up,
   input  logic         wrap_dn,
   input  logic         cu_level,
   input  logic         cd_level,
   output logic [W-1:0] status_o,
   output logic         ovf_pulse_o,
   output logic         unf_pulse_o
);

   localparam int unsigned B_CU = W - OFS_CU;
   localparam int unsigned B_CD = W - OFS_CD;
   localparam int unsigned B_DN = W - OFS_DN;
   localparam int unsigned B_OV = W - OFS_OV;
   localparam int unsigned B_UN = W - OFS_UN;

   logic ovf_q, unf_q, done_q, op_q, up_q;
   logic ovf_d, unf_d, done_d;
   logic at_or_above;

   assign at_or_above = ($signed(acc_next) >= $signed(preset_next));
   assign ovf_d       = ~clr & (ovf_q | wrap_up);
   assign unf_d       = ~clr & (unf_q | wrap_dn);

   generate
      if (HOLD_DONE_WRAP) begin : g_done_hold
         assign done_d = ~clr & (at_or_above | (done_q & ovf_d));
      end else begin : g_done_plain
         assign done_d = ~clr & at_or_above;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_q  <= 1'b0;
         unf_q  <= 1'b0;
         done_q <= 1'b0;
         op_q   <= 1'b0;
         up_q   <= 1'b0;
      end else begin
         ovf_q  <= ovf_d;
         unf_q  <= unf_d;
         done_q <= done_d;
         op_q   <= ~clr & wrap_up & ~ovf_q;
         up_q   <= ~clr & wrap_dn & ~unf_q;
      end
   end

   always_comb begin
      status_o       = '0;
      status_o[B_CU] = cu_level;
      status_o[B_CD] = cd_level;
      status_o[B_DN] = done_q;
      status_o[B_OV] = ovf_q;
      status_o[B_UN] = unf_q;
   end

   assign ovf_pulse_o = op_q;
   assign unf_pulse_o = up_q;

endmodule

// File: rtl/scan_counter_elem.sv
module scan_counter_elem
   import scnt_pkg::*;
#(
   parameter int unsigned  W              = 16,
   parameter logic [W-1:0] PRESET_INIT    = '0,
   parameter bit           HOLD_DONE_WRAP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         scan,
   input  logic         cu_cond,
   input  logic         cd_cond,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         preset_we,
   input  logic [W-1:0] preset_val,
   output logic [W-1:0] status_word,
   output logic [W-1:0] preset_word,
   output logic [W-1:0] accum_word,
   output logic         ovf_pulse,
   output logic         unf_pulse
);

   localparam int unsigned NCH = 2;

   generate
      if (W < MIN_WIDTH) begin : g_bad_width
         $error("scan_counter_elem: W must be at least %0d", MIN_WIDTH);
      end
   endgenerate

   logic [NCH-1:0] cond_vec, rise_vec, level_vec;
   logic           up_edge, dn_edge;
   logic [W-1:0]   preset_q, preset_d, acc_next;
   logic           wrap_up, wrap_dn;

   assign cond_vec = {cd_cond, cu_cond};

   // Channel 0 counts up, channel 1 counts down.
   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         scnt_edge u_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .scan    (scan),
            .cond    (cond_vec[ch]),
            .rise_o  (rise_vec[ch]),
            .level_o (level_vec[ch])
         );
      end
   endgenerate

   assign up_edge = rise_vec[0];
   assign dn_edge = rise_vec[1];

   assign preset_d = preset_we ? preset_val : preset_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) preset_q <= PRESET_INIT;
      else        preset_q <= preset_d;
   end

   scnt_accum #(.W(W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .load_en    (load_en),
      .load_val   (load_val),
      .up_rise    (up_edge),
      .dn_rise    (dn_edge),
      .acc_o      (accum_word),
      .acc_next_o (acc_next),
      .wrap_up_o  (wrap_up),
      .wrap_dn_o  (wrap_dn)
   );

   scnt_status #(.W(W), .HOLD_DONE_WRAP(HOLD_DONE_WRAP)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .acc_next    (acc_next),
      .preset_next (preset_d),
      .wrap_up     (wrap_up),
      .wrap_dn     (wrap_dn),
      .cu_level    (level_vec[0]),
      .cd_level    (level_vec[1]),
      .status_o    (status_word),
      .ovf_pulse_o (ovf_pulse),
      .unf_pulse_o (unf_pulse)
   );

   assign preset_word = preset_q;

endmodule

// File: rtl/scnt_chk.sv
module scnt_chk
   import scnt_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clr,
   input logic         scan,
   input logic         load_en,
   input logic [W-1:0] load_val,
   input logic         up_edge,
   input logic         dn_edge,
   input logic [W-1:0] status_word,
   input logic [W-1:0] preset_word,
   input logic [W-1:0] accum_word,
   input logic         ovf_pulse,
   input logic         unf_pulse
);

   localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
   localparam int unsigned  B_DN = W - OFS_DN;
   localparam int unsigned  B_OV = W - OFS_OV;
   localparam int unsigned  B_UN = W - OFS_UN;

   p_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (accum_word == '0 && status_word == '0 && !ovf_pulse && !unf_pulse));

   p_edge_needs_scan_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !scan |-> (!up_edge && !dn_edge));

   p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load_en && up_edge && !dn_edge && accum_word != MAX_POS)
      |=> accum_word == $past(accum_word) + 1'b1);

   p_count_dn_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load_en && dn_edge && !up_edge && accum_word != MIN_NEG)
      |=> accum_word == $past(accum_word) - 1'b1);

   p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(clr) && !status_word[B_OV])
      |-> status_word[B_DN] == ($signed(accum_word) >= $signed(preset_word)));

   p_wrap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load_en && up_edge && !dn_edge && accum_word == MAX_POS)
      |=> (accum_word == MIN_NEG && status_word[B_OV]));

   p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word[B_OV] && !clr) |=> status_word[B_OV]);

   p_ovf_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (status_word[B_OV] && !$past(status_word[B_OV])));

   p_wrap_dn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load_en && dn_edge && !up_edge && accum_word == MIN_NEG)
      |=> (accum_word == MAX_POS && status_word[B_UN]));

   p_unf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word[B_UN] && !clr) |=> status_word[B_UN]);

   p_unf_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      unf_pulse |=> !unf_pulse);

   p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word[B_DN] && status_word[B_OV] && !clr) |=> status_word[B_DN]);

   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_en) |=> accum_word == $past(load_val));

   p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load_en && up_edge && dn_edge) |=> $stable(accum_word));

endmodule

bind scan_counter_elem scnt_chk #(.W(W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clr         (clr),
   .scan        (scan),
   .load_en     (load_en),
   .load_val    (load_val),
   .up_edge     (up_edge),
   .dn_edge     (dn_edge),
   .status_word (status_word),
   .preset_word (preset_word),
   .accum_word  (accum_word),
   .ovf_pulse   (ovf_pulse),
   .unf_pulse   (unf_pulse)
);

// File: tb/sim_scan_counter_elem.sv
`timescale 1ns/1ps
module sim_scan_counter_elem;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0, scan = 1'b0, cu_cond = 1'b0, cd_cond = 1'b0;
   logic        load_en = 1'b0, preset_we = 1'b0;
   logic [15:0] load_val = '0, preset_val = '0;
   logic [15:0] status_word, preset_word, accum_word;
   logic        ovf_pulse, unf_pulse;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   scan_counter_elem u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .scan(scan),
      .cu_cond(cu_cond), .cd_cond(cd_cond),
      .load_en(load_en), .load_val(load_val),
      .preset_we(preset_we), .preset_val(preset_val),
      .status_word(status_word), .preset_word(preset_word),
      .accum_word(accum_word), .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse)
   );

   // Reference model state
   logic [15:0] m_acc, m_pre;
   logic m_cuq, m_cdq, m_arm, m_done, m_ovf, m_unf, m_op, m_up;

   function automatic logic sge(input logic [15:0] a, input logic [15:0] b);
      return $signed(a) >= $signed(b);
   endfunction

   function automatic logic [15:0] m_status();
      return {m_cuq, m_cdq, m_done, m_ovf, m_unf, 11'b0};
   endfunction

   task automatic model_reset();
      m_acc = '0; m_pre = '0; m_cuq = 0; m_cdq = 0; m_arm = 0;
      m_done = 0; m_ovf = 0; m_unf = 0; m_op = 0; m_up = 0;
   endtask

   task automatic model_tick();
      logic ue, de, wo, wu;
      if (preset_we) m_pre = preset_val;
      if (clr) begin
         m_acc = '0; m_cuq = 0; m_cdq = 0; m_arm = 0;
         m_done = 0; m_ovf = 0; m_unf = 0; m_op = 0; m_up = 0;
      end else begin
         ue = scan && m_arm && cu_cond && !m_cuq;
         de = scan && m_arm && cd_cond && !m_cdq;
         if (scan) begin m_cuq = cu_cond; m_cdq = cd_cond; m_arm = 1; end
         wo = 0; wu = 0;
         if (load_en) m_acc = load_val;
         else if (ue && !de) begin wo = (m_acc == 16'h7FFF); m_acc = m_acc + 16'd1; end
         else if (de && !ue) begin wu = (m_acc == 16'h8000); m_acc = m_acc - 16'd1; end
         m_op = wo && !m_ovf;
         m_up = wu && !m_unf;
         if (wo) m_ovf = 1;
         if (wu) m_unf = 1;
         m_done = sge(m_acc, m_pre) || (m_done && m_ovf);
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic chk_all();
      chk("R2 R3 R9 accumulator", {16'd0, accum_word}, {16'd0, m_acc});
      chk("R4 R5 R8 status word", {16'd0, status_word}, {16'd0, m_status()});
      chk("R12 preset word", {16'd0, preset_word}, {16'd0, m_pre});
      chk("R6 ovf pulse", {31'd0, ovf_pulse}, {31'd0, m_op});
      chk("R7 unf pulse", {31'd0, unf_pulse}, {31'd0, m_up});
   endtask

   // One cycle: inputs are set at the falling edge, the model advances at
   // the rising edge, and outputs are compared at the next falling edge.
   task automatic step(input logic s, input logic cu, input logic cd,
                       input logic ld, input logic [15:0] lv,
                       input logic pw, input logic [15:0] pv, input logic c);
      scan = s; cu_cond = cu; cd_cond = cd; load_en = ld; load_val = lv;
      preset_we = pw; preset_val = pv; clr = c;
      @(posedge clk);
      model_tick();
      @(negedge clk);
      chk_all();
   endtask

   task automatic idle();
      step(0, cu_cond, cd_cond, 0, 16'd0, 0, 16'd0, 0);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      chk("R1 reset accum", {16'd0, accum_word}, 32'd0);
      chk("R1 reset status", {16'd0, status_word}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 preset write
      step(0, 0, 0, 0, 16'd0, 1, 16'd3, 0);
      chk("R12 preset written", {16'd0, preset_word}, 32'd3);
      // Arm strobe (R11), then count three up edges (R2)
      step(1, 0, 0, 0, 16'd0, 0, 16'd0, 0);
      for (int i = 0; i < 3; i++) begin
         step(1, 1, 0, 0, 16'd0, 0, 16'd0, 0);
         step(1, 0, 0, 0, 16'd0, 0, 16'd0, 0);
      end
      chk("R2 three up edges", {16'd0, accum_word}, 32'd3);
      chk("R5 done at preset", {31'd0, status_word[13]}, 32'd1);
      // Held condition counts once (R2), and level shows in bit 15 (R4)
      step(1, 1, 0, 0, 16'd0, 0, 16'd0, 0);
      step(1, 1, 0, 0, 16'd0, 0, 16'd0, 0);
      step(1, 1, 0, 0, 16'd0, 0, 16'd0, 0);
      chk("R2 held counts once", {16'd0, accum_word}, 32'd4);
      chk("R4 up level bit", {31'd0, status_word[15]}, 32'd1);
      // Toggles without strobe are ignored (R2)
      step(0, 0, 0, 0, 16'd0, 0, 16'd0, 0);
      step(0, 1, 0, 0, 16'd0, 0, 16'd0, 0);
      step(0, 0, 0, 0, 16'd0, 0, 16'd0, 0);
      chk("R2 no strobe no count", {16'd0, accum_word}, 32'd4);
      step(1, 0, 0, 0, 16'd0, 0, 16'd0, 0);
      // Simultaneous edges cancel (R10)
      step(1, 1, 1, 0, 16'd0, 0, 16'd0, 0);
      chk("R10 cancel", {16'd0, accum_word}, 32'd4);
      chk("R4 both levels", {30'd0, status_word[15:14]}, 32'd3);
      step(1, 0, 0, 0, 16'd0, 0, 16'd0, 0);
      // Load 50, preset 0, count down to 0 (R3, R9, R5)
      step(0, 0, 0, 1, 16'd50, 1, 16'd0, 0);
      chk("R9 load 50", {16'd0, accum_word}, 32'd50);
      for (int i = 0; i < 50; i++) begin
         step(1, 0, 1, 0, 16'd0, 0, 16'd0, 0);
         step(1, 0, 0, 0, 16'd0, 0, 16'd0, 0);
      end
      chk("R3 down to zero", {16'd0, accum_word}, 32'd0);
      chk("R5 done at zero", {31'd0, status_word[13]}, 32'd1);
      step(1, 0, 1, 0, 16'd0, 0, 16'd0, 0);
      chk("R5 below preset", {31'd0, status_word[13]}, 32'd0);
      step(1, 0, 0, 0, 16'd0, 0, 16'd0, 0);
      // Load beats count (R9)
      step(1, 1, 0, 1, 16'd7, 0, 16'd0, 0);
      chk("R9 load over count", {16'd0, accum_word}, 32'd7);
      step(1, 0, 0, 0, 16'd0, 0, 16'd0, 0);
      // Overflow wrap with held done (R6, R8)
      step(0, 0, 0, 1, 16'h7FFF, 1, 16'd100, 0);
      step(1, 1, 0, 0, 16'd0, 0, 16'd0, 0);
      chk("R6 wrap to min", {16'd0, accum_word}, 32'h8000);
      chk("R6 ovf set", {31'd0, status_word[12]}, 32'd1);
      chk("R6 ovf pulse", {31'd0, ovf_pulse}, 32'd1);
      chk("R8 done held", {31'd0, status_word[13]}, 32'd1);
      idle();
      chk("R6 pulse one cycle", {31'd0, ovf_pulse}, 32'd0);
      chk("R6 ovf sticky", {31'd0, status_word[12]}, 32'd1);
      // Underflow wrap (R7)
      step(1, 0, 0, 1, 16'h8000, 0, 16'd0, 0);
      step(1, 0, 1, 0, 16'd0, 0, 16'd0, 0);
      chk("R7 wrap to max", {16'd0, accum_word}, 32'h7FFF);
      chk("R7 unf set", {31'd0, status_word[11]}, 32'd1);
      chk("R7 unf pulse", {31'd0, unf_pulse}, 32'd1);
      idle();
      chk("R7 unf sticky", {31'd0, status_word[11]}, 32'd1);
      // Clear with condition held high across release (R1, R11)
      step(1, 1, 0, 0, 16'd0, 0, 16'd0, 1);
      chk("R1 clear accum", {16'd0, accum_word}, 32'd0);
      chk("R1 clear status", {16'd0, status_word}, 32'd0);
      chk("R1 preset kept", {16'd0, preset_word}, 32'd100);
      step(1, 1, 0, 0, 16'd0, 0, 16'd0, 0);
      step(1, 1, 0, 0, 16'd0, 0, 16'd0, 0);
      chk("R11 no count after clear", {16'd0, accum_word}, 32'd0);
      chk("R12 low bits zero", {21'd0, status_word[10:0]}, 32'd0);

      // Constrained random phase
      for (int k = 0; k < 4000; k++) begin
         logic [15:0] lv;
         logic [2:0]  pick;
         pick = 3'($urandom_range(0, 7));
         case (pick)
            3'd0: lv = 16'h7FFE;
            3'd1: lv = 16'h7FFF;
            3'd2: lv = 16'h8000;
            3'd3: lv = 16'h8001;
            default: lv = 16'($urandom);
         endcase
         step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), ($urandom_range(0, 31) == 0), lv,
              ($urandom_range(0, 31) == 0), 16'($urandom_range(0, 8)) - 16'd4,
              ($urandom_range(0, 63) == 0));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule